// File: doc/BRIEF.md
# DRAM Low-Power Mode Sequencer

This block decides when a DRAM interface drops into a low-power state and when it comes back. It watches a host access request and a transfer-busy flag and counts consecutive idle cycles. When the count reaches a selectable delay, it moves the memory into self-refresh, power-down or deep power-down. The active mode selector chooses which of these three is used. Each transition is reported as a one-cycle command strobe with a command code. The block also drives the CKE level and an enable for the memory clock gate.

An access that arrives while the memory sleeps in self-refresh or power-down wakes it. The block issues an exit command and raises CKE, then waits a fixed exit delay before it grants the access. Once the access has finished and the bus is idle again, the idle delay runs again and the memory goes back to sleep. Deep power-down is left only through a re-init pulse. A separate power-off input pulls CKE low at once, whatever the sequencer is doing.

Top module: `dram_lp_seq`

## Requirements
- R1: While and right after synchronous reset (rst_n low), the sequencer is awake: cke_o=1, clk_en_o=1, sr_done_o=0, grant_o=0, cmd_valid_o=0.
- R2: With mode_i=0, no entry command is ever strobed and cke_o stays 1, however long the bus stays idle.
- R3: tmo_sel_i picks the idle delay. A value of 0 or 3 enters on the first idle clock edge. A value of 1 enters on the 65th consecutive idle edge, and a value of 2 enters on the 129th.
- R4: With mode_i=1, entry strobes command code 1 (self-refresh enter) for one cycle. It also drives cke_o=0 and clk_en_o=0 and sets sr_done_o=1, which stays 1 only while in self-refresh.
- R5: With mode_i=2, entry strobes command code 3 (power-down enter) and drives cke_o=0. In power-down, clk_en_o equals the inverse of clk_freeze_i.
- R6: With mode_i=3, entry strobes command code 5 (deep power-down enter) and drives cke_o=0 and clk_en_o=0. A request does not wake the memory from this state. A reinit_i pulse returns it to the awake state with cke_o=1 and no command strobe.
- R7: A request in self-refresh or power-down strobes the exit command on the next edge: code 2 leaves self-refresh and code 4 leaves power-down. The same edge raises cke_o and clears sr_done_o. grant_o stays 0 for EXIT_DLY cycles (2 by default) and rises on the following edge.
- R8: After a woken access, the memory re-enters the low-power state once req_i and busy_i are both low for the selected idle delay.
- R9: A high req_i or busy_i, or a change of mode_i or tmo_sel_i, restarts the idle count from zero.
- R10: While pwr_off_i is 1, cke_o is 0 in every state.
- R11: grant_o is 1 only when awake with req_i high, and never in self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Low-power mode: 0 none, 1 self-refresh, 2 power-down, 3 deep power-down |
| tmo_sel_i | input | 2 | Idle delay: 0 none, 1 short, 2 long, 3 treated as 0 |
| clk_freeze_i | input | 1 | Stop the memory clock during power-down |
| pwr_off_i | input | 1 | Force CKE low for a power-off sequence |
| reinit_i | input | 1 | Leave deep power-down |
| req_i | input | 1 | Host access request, held until granted |
| busy_i | input | 1 | A transfer is in progress |
| grant_o | output | 1 | Access may proceed |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_o | output | 3 | Command code: 1 SR enter, 2 SR exit, 3 PD enter, 4 PD exit, 5 DPD enter |
| cke_o | output | 1 | Clock-enable level to the memory |
| clk_en_o | output | 1 | Enable for the memory clock gate |
| sr_done_o | output | 1 | Memory is in self-refresh |

## Verification
The properties assume that a requester holds req_i high until grant_o rises. They also assume that reinit_i is pulsed only while the memory sits in deep power-down, and that EXIT_DLY is at least 1. The directed stimulus follows these rules. Each scenario starts from reset with the configuration already applied, so the idle counter begins at a known zero. Inputs change only on the falling clock edge, so every expected transition can be counted edge by edge from the idle delay and the exit delay.

// File: rtl/dlp_pkg.sv
// Shared types for the DRAM low-power sequencer.
// Assumes: command codes are decoded by a downstream command encoder.
package dlp_pkg;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_SR_ENTER  = 3'd1,
        CMD_SR_EXIT   = 3'd2,
        CMD_PD_ENTER  = 3'd3,
        CMD_PD_EXIT   = 3'd4,
        CMD_DPD_ENTER = 3'd5
    } lp_cmd_e;

    typedef enum logic [2:0] {
        ST_AWAKE = 3'd0,
        ST_SELF  = 3'd1,
        ST_PDOWN = 3'd2,
        ST_DEEP  = 3'd3,
        ST_WAKE  = 3'd4
    } lp_state_e;

    localparam logic [1:0] MODE_OFF  = 2'd0;
    localparam logic [1:0] MODE_SELF = 2'd1;
    localparam logic [1:0] MODE_PD   = 2'd2;
    localparam logic [1:0] MODE_DEEP = 2'd3;

endpackage

// File: rtl/dlp_idle_timer.sv
// Idle-cycle counter. It counts consecutive idle cycles while enabled and
// reports expiry when the count reaches the selected delay.
// Assumes: the cfg_* inputs are quasi-static; any change restarts the count.
module dlp_idle_timer #(
    parameter int SHORT_DLY = 64,
    parameter int LONG_DLY  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       idle_i,
    input  logic [1:0] cfg_mode_i,
    input  logic [1:0] cfg_tmo_i,
    output logic       expire_o
);
    localparam int CNT_W = $clog2(LONG_DLY + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [1:0]       mode_q;
    logic [1:0]       tmo_q;
    logic             clr;

    // Select the delay limit; the reserved code behaves like zero.
    always_comb begin
        case (cfg_tmo_i)
            2'd1:    limit = CNT_W'(SHORT_DLY);
            2'd2:    limit = CNT_W'(LONG_DLY);
            default: limit = '0;
        endcase
    end

    assign clr      = !en_i || !idle_i || (cfg_mode_i != mode_q) || (cfg_tmo_i != tmo_q);
    assign expire_o = !clr && (cnt_q == limit);

    // Track configuration and count idle cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= cfg_mode_i;
            tmo_q  <= cfg_tmo_i;
        end else begin
            mode_q <= cfg_mode_i;
            tmo_q  <= cfg_tmo_i;
            if (clr)
                cnt_q <= '0;
            else if (cnt_q != limit)
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dlp_mode_fsm.sv
// Low-power state machine. It enters the selected state on expiry, wakes
// on a request, waits EXIT_DLY cycles before going awake, and leaves deep
// power-down only on re-init. A one-cycle command strobe marks each move.
// Assumes: EXIT_DLY >= 1; req_i is held until granted.
module dlp_mode_fsm
    import dlp_pkg::*;
#(
    parameter int EXIT_DLY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire_i,
    input  logic [1:0] mode_i,
    input  logic       req_i,
    input  logic       reinit_i,
    output lp_state_e  state_o,
    output logic       cmd_valid_o,
    output lp_cmd_e    cmd_o
);
    localparam int WK_W = $clog2(EXIT_DLY + 1);

    lp_state_e       state_q;
    logic [WK_W-1:0] wcnt_q;

    assign state_o = state_q;

    // Advance the state, strobe commands and time the exit delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_AWAKE;
            wcnt_q      <= '0;
            cmd_valid_o <= 1'b0;
            cmd_o       <= CMD_NOP;
        end else begin
            cmd_valid_o <= 1'b0;
            cmd_o       <= CMD_NOP;
            case (state_q)
                ST_AWAKE: begin
                    if (expire_i) begin
                        case (mode_i)
                            MODE_SELF: begin
                                state_q     <= ST_SELF;
                                cmd_valid_o <= 1'b1;
                                cmd_o       <= CMD_SR_ENTER;
                            end
                            MODE_PD: begin
                                state_q     <= ST_PDOWN;
                                cmd_valid_o <= 1'b1;
                                cmd_o       <= CMD_PD_ENTER;
                            end
                            MODE_DEEP: begin
                                state_q     <= ST_DEEP;
                                cmd_valid_o <= 1'b1;
                                cmd_o       <= CMD_DPD_ENTER;
                            end
                            default: state_q <= ST_AWAKE;
                        endcase
                    end
                end
                ST_SELF: begin
                    if (req_i) begin
                        state_q     <= ST_WAKE;
                        wcnt_q      <= '0;
                        cmd_valid_o <= 1'b1;
                        cmd_o       <= CMD_SR_EXIT;
                    end
                end
                ST_PDOWN: begin
                    if (req_i) begin
                        state_q     <= ST_WAKE;
                        wcnt_q      <= '0;
                        cmd_valid_o <= 1'b1;
                        cmd_o       <= CMD_PD_EXIT;
                    end
                end
                ST_DEEP: begin
                    if (reinit_i)
                        state_q <= ST_AWAKE;
                end
                ST_WAKE: begin
                    if (wcnt_q == WK_W'(EXIT_DLY - 1))
                        state_q <= ST_AWAKE;
                    else
                        wcnt_q <= wcnt_q + 1'b1;
                end
                default: state_q <= ST_AWAKE;
            endcase
        end
    end
endmodule

// File: rtl/dlp_pin_drive.sv
// Output stage. It turns the sequencer state into the CKE level, the
// clock-gate enable, the self-refresh status and the access grant.
// Assumes: pwr_off_i may arrive at any time and overrides CKE alone.
module dlp_pin_drive
    import dlp_pkg::*;
(
    input  lp_state_e state_i,
    input  logic      clk_freeze_i,
    input  logic      pwr_off_i,
    input  logic      req_i,
    output logic      cke_o,
    output logic      clk_en_o,
    output logic      sr_done_o,
    output logic      grant_o
);
    logic sleeping;

    // Derive the pin levels from the state.
    always_comb begin
        sleeping  = (state_i == ST_SELF) || (state_i == ST_PDOWN) || (state_i == ST_DEEP);
        cke_o     = !sleeping && !pwr_off_i;
        sr_done_o = (state_i == ST_SELF);
        grant_o   = (state_i == ST_AWAKE) && req_i;
        case (state_i)
            ST_SELF, ST_DEEP: clk_en_o = 1'b0;
            ST_PDOWN:         clk_en_o = !clk_freeze_i;
            default:          clk_en_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dram_lp_seq.sv
// Top of the DRAM low-power sequencer. It wires the idle timer, the mode
// state machine and the output stage together.
// Assumes: one clock domain; all inputs synchronous to clk.
module dram_lp_seq
    import dlp_pkg::*;
#(
    parameter int SHORT_DLY = 64,
    parameter int LONG_DLY  = 128,
    parameter int EXIT_DLY  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic [1:0] tmo_sel_i,
    input  logic       clk_freeze_i,
    input  logic       pwr_off_i,
    input  logic       reinit_i,
    input  logic       req_i,
    input  logic       busy_i,
    output logic       grant_o,
    output logic       cmd_valid_o,
    output logic [2:0] cmd_o,
    output logic       cke_o,
    output logic       clk_en_o,
    output logic       sr_done_o
);
    lp_state_e state;
    lp_cmd_e   cmd;
    logic      expire;
    logic      timer_en;

    assign timer_en = (state == ST_AWAKE) && (mode_i != MODE_OFF);
    assign cmd_o    = cmd;

    dlp_idle_timer #(
        .SHORT_DLY(SHORT_DLY),
        .LONG_DLY (LONG_DLY)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (timer_en),
        .idle_i    (!req_i && !busy_i),
        .cfg_mode_i(mode_i),
        .cfg_tmo_i (tmo_sel_i),
        .expire_o  (expire)
    );

    dlp_mode_fsm #(
        .EXIT_DLY(EXIT_DLY)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (expire),
        .mode_i     (mode_i),
        .req_i      (req_i),
        .reinit_i   (reinit_i),
        .state_o    (state),
        .cmd_valid_o(cmd_valid_o),
        .cmd_o      (cmd)
    );

    dlp_pin_drive u_pins (
        .state_i     (state),
        .clk_freeze_i(clk_freeze_i),
        .pwr_off_i   (pwr_off_i),
        .req_i       (req_i),
        .cke_o       (cke_o),
        .clk_en_o    (clk_en_o),
        .sr_done_o   (sr_done_o),
        .grant_o     (grant_o)
    );
endmodule

// File: rtl/dlp_checks.sv
// Port-level properties of the DRAM low-power sequencer, bound to the top.
// Assumes: req_i is held until granted; reinit_i is used only in deep power-down.
module dlp_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic [1:0] tmo_sel_i,
    input logic       clk_freeze_i,
    input logic       pwr_off_i,
    input logic       reinit_i,
    input logic       req_i,
    input logic       busy_i,
    input logic       grant_o,
    input logic       cmd_valid_o,
    input logic [2:0] cmd_o,
    input logic       cke_o,
    input logic       clk_en_o,
    input logic       sr_done_o
);
    logic is_entry;
    logic is_exit;
    assign is_entry = cmd_valid_o && (cmd_o == 3'd1 || cmd_o == 3'd3 || cmd_o == 3'd5);
    assign is_exit  = cmd_valid_o && (cmd_o == 3'd2 || cmd_o == 3'd4);

    // Self-refresh status implies CKE low and memory clock stopped.
    p_sr_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sr_done_o |-> (!cke_o && !clk_en_o));

    // Forced power-off holds CKE low.
    p_pwroff_cke_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_i |-> !cke_o);

    // A grant only goes to a pending request outside self-refresh.
    p_grant_awake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (req_i && !sr_done_o && (cke_o || pwr_off_i)));

    // Leaving self-refresh is always marked by the exit command.
    p_sr_exit_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_done_o) |-> (cmd_valid_o && cmd_o == 3'd2));

    // An exit strobe comes with CKE high and no grant yet.
    p_exit_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_exit |-> ((cke_o || pwr_off_i) && !grant_o));

    // No entry command is issued under mode 0.
    p_no_entry_mode0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_entry |-> ($past(mode_i) != 2'd0));

    // Deep power-down entry drops CKE and the memory clock.
    p_deep_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == 3'd5) |-> (!cke_o && !clk_en_o));
endmodule

bind dram_lp_seq dlp_checks u_chk (.*);

// File: tb/dram_lp_seq_tb.sv
`timescale 1ns/1ps
module dram_lp_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic [1:0] tmo;
    logic       freeze, pwroff, reinit, req, busy;
    logic       grant, cmd_valid, cke, clk_en, sr_done;
    logic [2:0] cmd;
    int         n_checks = 0;
    int         n_errors = 0;

    always #5 clk = ~clk;

    dram_lp_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .tmo_sel_i(tmo),
        .clk_freeze_i(freeze), .pwr_off_i(pwroff), .reinit_i(reinit),
        .req_i(req), .busy_i(busy), .grant_o(grant), .cmd_valid_o(cmd_valid),
        .cmd_o(cmd), .cke_o(cke), .clk_en_o(clk_en), .sr_done_o(sr_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic [1:0] m, input logic [1:0] t);
        rst_n = 1'b0; mode = m; tmo = t; req = 0; busy = 0;
        freeze = 0; pwroff = 0; reinit = 0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_r1();
        start(2'd1, 2'd0);
        rst_n = 1'b0; tick(1);
        chk("R1 cke in reset", cke, 1);
        chk("R1 clk_en in reset", clk_en, 1);
        chk("R1 sr_done in reset", sr_done, 0);
        chk("R1 cmd_valid in reset", cmd_valid, 0);
        chk("R1 grant in reset", grant, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_mode_off_r2();
        int strobes = 0;
        start(2'd0, 2'd0);
        for (int i = 0; i < 200; i++) begin
            tick(1);
            if (cmd_valid || !cke) strobes++;
        end
        chk("R2 no entry in mode 0", strobes, 0);
    endtask

    task automatic t_delay_r3(input logic [1:0] t, input int edges);
        start(2'd1, t);
        if (edges > 1) begin
            tick(edges - 1);
            chk($sformatf("R3 tmo=%0d not yet", t), sr_done, 0);
            tick(1);
        end else begin
            tick(1);
        end
        chk($sformatf("R3 tmo=%0d entered", t), sr_done, 1);
    endtask

    task automatic t_self_r4_r7_r8();
        start(2'd1, 2'd0);
        tick(1);
        chk("R4 SR enter strobe", cmd_valid, 1);
        chk("R4 SR enter code", cmd, 1);
        chk("R4 cke low", cke, 0);
        chk("R4 clk_en low", clk_en, 0);
        chk("R4 sr_done", sr_done, 1);
        tick(1);
        chk("R4 strobe one cycle", cmd_valid, 0);
        req = 1; tick(1);
        chk("R7 SR exit code", cmd_valid ? cmd : 0, 2);
        chk("R7 cke high on exit", cke, 1);
        chk("R7 sr_done cleared", sr_done, 0);
        chk("R7 no grant delay 1", grant, 0);
        tick(1);
        chk("R7 no grant delay 2", grant, 0);
        tick(1);
        chk("R7 grant after delay", grant, 1);
        chk("R11 grant while awake", cke, 1);
        req = 0; busy = 1; tick(3);
        chk("R8 stays awake while busy", sr_done, 0);
        busy = 0; tick(1);
        chk("R8 re-entry after access", sr_done, 1);
    endtask

    task automatic t_pdown_r5();
        start(2'd2, 2'd0);
        tick(1);
        chk("R5 PD enter code", cmd_valid ? cmd : 0, 3);
        chk("R5 cke low", cke, 0);
        chk("R5 clk_en free running", clk_en, 1);
        chk("R5 no sr_done", sr_done, 0);
        freeze = 1; tick(1);
        chk("R5 clk_en frozen", clk_en, 0);
        req = 1; tick(1);
        chk("R7 PD exit code", cmd_valid ? cmd : 0, 4);
        chk("R7 cke high after PD exit", cke, 1);
        tick(2);
        chk("R7 grant after PD exit", grant, 1);
        req = 0;
    endtask

    task automatic t_deep_r6();
        start(2'd3, 2'd0);
        tick(1);
        chk("R6 DPD enter code", cmd_valid ? cmd : 0, 5);
        chk("R6 cke low", cke, 0);
        chk("R6 clk_en low", clk_en, 0);
        req = 1; tick(5);
        chk("R6 request ignored cke", cke, 0);
        chk("R6 request ignored grant", grant, 0);
        chk("R6 request ignored strobe", cmd_valid, 0);
        reinit = 1; tick(1); reinit = 0;
        chk("R6 reinit cke high", cke, 1);
        chk("R6 reinit no strobe", cmd_valid, 0);
        chk("R6 grant after reinit", grant, 1);
        req = 0;
    endtask

    task automatic t_clear_r9();
        start(2'd1, 2'd1);
        tick(40);
        busy = 1; tick(1); busy = 0;
        tick(64);
        chk("R9 busy restarts count", sr_done, 0);
        tick(1);
        chk("R9 entry after restart", sr_done, 1);
        start(2'd1, 2'd1);
        tick(40);
        mode = 2'd2; tick(1);
        tick(64);
        chk("R9 mode change restarts count", cke, 1);
        tick(1);
        chk("R9 PD entry after restart", cmd_valid ? cmd : 0, 3);
    endtask

    task automatic t_pwroff_r10();
        start(2'd0, 2'd0);
        tick(1);
        pwroff = 1; #1;
        chk("R10 cke forced low awake", cke, 0);
        pwroff = 0; #1;
        chk("R10 cke released", cke, 1);
        mode = 2'd2; tick(2);
        pwroff = 1; #1;
        chk("R10 cke low in power-down", cke, 0);
        pwroff = 0;
    endtask

    initial begin
        #2000000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_mode_off_r2();
        t_delay_r3(2'd0, 1);
        t_delay_r3(2'd3, 1);
        t_delay_r3(2'd1, 65);
        t_delay_r3(2'd2, 129);
        t_self_r4_r7_r8();
        t_pdown_r5();
        t_deep_r6();
        t_clear_r9();
        t_pwroff_r10();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule